// File: doc/BRIEF.md
# Tagged-Register Loop Issue Sequencer

This block sits between instruction decode and the execution units. Decode hands it one scalar instruction at a time: an opcode plus a destination and two source register numbers. Each register number is looked up in a 32-entry tag table. If none of the three is tagged, the instruction passes through as a single micro-op.

If at least one operand is tagged, the instruction is treated as a vector operation. In hardware-loop mode the block issues one micro-op per cycle, as many as the programmed length. Every tagged operand's register number rises by the element index on each issue, wrapping modulo 32. Untagged operands keep their number. While the loop runs, decode is stalled and a PC-hold output keeps the program counter frozen. In trap mode the block issues nothing for a tagged instruction and pulses an exception strobe, so software can carry out the loop instead.

The tag table, the length and the mode are written through three small write ports. A value written takes effect from the next instruction accepted after the write edge.

Top module: `tagvec_issue_seq`

## Requirements
- R1: An instruction with no tagged operand issues exactly one micro-op, one cycle after acceptance, with its opcode and register numbers unchanged, `uop_last`=1 and `pc_hold`=0.
- R2: In hardware-loop mode (`mode_val`=0), a tagged instruction with length L>=2 issues L micro-ops on L consecutive cycles, starting one cycle after acceptance. All of them carry the same opcode, and `uop_last`=1 only on the final one.
- R3: On element i (counting from 0), a tagged operand carries (base + i) mod 32 and an untagged operand carries its base number.
- R4: A tagged instruction with a length value of 0 or 1 issues a single micro-op with `uop_last`=1 and `pc_hold`=0.
- R5: `pc_hold` is 1 on every issued micro-op except the last one of an instruction, and 0 otherwise.
- R6: `in_ready` is 0 from the cycle after a multi-element acceptance up to the cycle before the last element appears. It is 1 in the cycle the last element appears, so the next instruction can be accepted back to back.
- R7: In trap mode (`mode_val`=1), a tagged instruction issues no micro-op and raises `trap` for exactly the one cycle after acceptance; `in_ready` stays 1. Untagged instructions issue normally in trap mode.
- R8: A tag write (`tag_val`=1 tags the register `tag_idx`, 0 untags it) affects only instructions accepted after the write edge. An instruction accepted on the same edge as the write sees the old tag.
- R9: The length and mode are captured when an instruction is accepted. Writing either of them, or the tag table, while a loop is running leaves the running loop unchanged.
- R10: After reset, no micro-op and no trap are output, `in_ready` is 1, every tag is clear, the length is 0 and the mode is hardware loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tag_we | input | 1 | Tag table write strobe |
| tag_idx | input | 5 | Register number whose tag is written |
| tag_val | input | 1 | New tag value (1 = tagged) |
| len_we | input | 1 | Length write strobe |
| len_val | input | 6 | New loop length |
| mode_we | input | 1 | Mode write strobe |
| mode_val | input | 1 | New mode (0 = hardware loop, 1 = trap) |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Sequencer can accept an instruction |
| in_op | input | 8 | Decoded opcode |
| in_rd | input | 5 | Destination register number |
| in_rs1 | input | 5 | First source register number |
| in_rs2 | input | 5 | Second source register number |
| uop_valid | output | 1 | Micro-op issued this cycle |
| uop_op | output | 8 | Micro-op opcode |
| uop_rd | output | 5 | Micro-op destination register |
| uop_rs1 | output | 5 | Micro-op first source register |
| uop_rs2 | output | 5 | Micro-op second source register |
| uop_last | output | 1 | Final micro-op of the instruction |
| pc_hold | output | 1 | Keep the program counter frozen |
| trap | output | 1 | Exception strobe for a tagged instruction in trap mode |

## Verification
A wrong element counter shows up as a wrong register number on the very next micro-op, or as a loop that runs one element too long or too short, so `uop_last`, `pc_hold` and `in_ready` move in the wrong cycle. A stale tag or a stale length shows on the first micro-op, or as a missing trap, for the instruction accepted right after the write. Every combination of tagged operands is swept against lengths 0 to 6, and wrap at register 31 is checked with a length of 32.

// File: rtl/tvs_pkg.sv
package tvs_pkg;
  typedef enum logic {
    MODE_LOOP = 1'b0,
    MODE_TRAP = 1'b1
  } exec_mode_e;
endpackage

// File: rtl/tvs_tag_table.sv
module tvs_tag_table #(
  parameter int REG_W = 5,
  parameter int NPORT = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [REG_W-1:0]            wr_idx,
  input  logic                        wr_val,
  input  logic [NPORT-1:0][REG_W-1:0] rd_idx,
  output logic [NPORT-1:0]            rd_tag
);
  localparam int NREG = 1 << REG_W;

  logic [NREG-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q <= '0;
    end else if (wr_en) begin
      tag_q[wr_idx] <= wr_val;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_look
    assign rd_tag[p] = tag_q[rd_idx[p]];
  end
endmodule

// File: rtl/tvs_cfg_regs.sv
module tvs_cfg_regs #(
  parameter int LEN_W = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  len_we,
  input  logic [LEN_W-1:0]      len_val,
  input  logic                  mode_we,
  input  logic                  mode_val,
  output logic [LEN_W-1:0]      len_q,
  output tvs_pkg::exec_mode_e   mode_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      len_q  <= '0;
      mode_q <= tvs_pkg::MODE_LOOP;
    end else begin
      if (len_we)  len_q  <= len_val;
      if (mode_we) mode_q <= tvs_pkg::exec_mode_e'(mode_val);
    end
  end
endmodule

// File: rtl/tvs_issue_loop.sv
module tvs_issue_loop #(
  parameter int REG_W = 5,
  parameter int LEN_W = 6,
  parameter int OP_W  = 8,
  parameter int NOPND = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic [OP_W-1:0]             in_op,
  input  logic [NOPND-1:0][REG_W-1:0] in_regs,
  input  logic [NOPND-1:0]            in_tags,
  input  logic [LEN_W-1:0]            cfg_len,
  input  tvs_pkg::exec_mode_e         cfg_mode,
  output logic                        in_ready,
  output logic                        uop_valid,
  output logic [OP_W-1:0]             uop_op,
  output logic [NOPND-1:0][REG_W-1:0] uop_regs,
  output logic                        uop_last,
  output logic                        pc_hold,
  output logic                        trap
);
  logic                        busy_q;
  logic [LEN_W-1:0]            idx_q;
  logic [LEN_W-1:0]            len_q;
  logic [OP_W-1:0]             hold_op;
  logic [NOPND-1:0][REG_W-1:0] hold_regs;
  logic [NOPND-1:0]            hold_tags;

  logic accept, tag_any, go_trap, go_issue, single, final_el;
  logic [REG_W-1:0]            idx_r;
  logic [NOPND-1:0][REG_W-1:0] step_regs;

  assign in_ready = ~busy_q;
  assign accept   = in_valid & ~busy_q;
  assign tag_any  = |in_tags;
  assign go_trap  = accept & tag_any & (cfg_mode == tvs_pkg::MODE_TRAP);
  assign go_issue = accept & ~go_trap;
  assign single   = ~tag_any | (cfg_len <= LEN_W'(1));
  assign final_el = (idx_q + LEN_W'(1)) == len_q;
  assign idx_r    = REG_W'(idx_q);

  for (genvar k = 0; k < NOPND; k++) begin : g_step
    assign step_regs[k] = hold_tags[k] ? hold_regs[k] + idx_r : hold_regs[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      idx_q     <= '0;
      len_q     <= '0;
      hold_op   <= '0;
      hold_regs <= '0;
      hold_tags <= '0;
      uop_valid <= 1'b0;
      uop_op    <= '0;
      uop_regs  <= '0;
      uop_last  <= 1'b0;
      pc_hold   <= 1'b0;
      trap      <= 1'b0;
    end else begin
      trap <= go_trap;
      if (go_issue) begin
        uop_valid <= 1'b1;
        uop_op    <= in_op;
        uop_regs  <= in_regs;
        uop_last  <= single;
        pc_hold   <= ~single;
        busy_q    <= ~single;
        idx_q     <= LEN_W'(1);
        len_q     <= cfg_len;
        hold_op   <= in_op;
        hold_regs <= in_regs;
        hold_tags <= in_tags;
      end else if (busy_q) begin
        uop_valid <= 1'b1;
        uop_op    <= hold_op;
        uop_regs  <= step_regs;
        uop_last  <= final_el;
        pc_hold   <= ~final_el;
        busy_q    <= ~final_el;
        idx_q     <= idx_q + LEN_W'(1);
      end else begin
        uop_valid <= 1'b0;
        uop_last  <= 1'b0;
        pc_hold   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tagvec_issue_seq.sv
module tagvec_issue_seq #(
  parameter int REG_W = 5,
  parameter int LEN_W = 6,
  parameter int OP_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tag_we,
  input  logic [REG_W-1:0] tag_idx,
  input  logic             tag_val,
  input  logic             len_we,
  input  logic [LEN_W-1:0] len_val,
  input  logic             mode_we,
  input  logic             mode_val,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OP_W-1:0]  in_op,
  input  logic [REG_W-1:0] in_rd,
  input  logic [REG_W-1:0] in_rs1,
  input  logic [REG_W-1:0] in_rs2,
  output logic             uop_valid,
  output logic [OP_W-1:0]  uop_op,
  output logic [REG_W-1:0] uop_rd,
  output logic [REG_W-1:0] uop_rs1,
  output logic [REG_W-1:0] uop_rs2,
  output logic             uop_last,
  output logic             pc_hold,
  output logic             trap
);
  localparam int NOPND = 3;

  logic [NOPND-1:0][REG_W-1:0] opnd_regs;
  logic [NOPND-1:0][REG_W-1:0] out_regs;
  logic [NOPND-1:0]            opnd_tags;
  logic [LEN_W-1:0]            cfg_len;
  tvs_pkg::exec_mode_e         cfg_mode;

  assign opnd_regs = {in_rs2, in_rs1, in_rd};
  assign uop_rd    = out_regs[0];
  assign uop_rs1   = out_regs[1];
  assign uop_rs2   = out_regs[2];

  tvs_tag_table #(.REG_W(REG_W), .NPORT(NOPND)) u_tags (
    .clk(clk), .rst(rst),
    .wr_en(tag_we), .wr_idx(tag_idx), .wr_val(tag_val),
    .rd_idx(opnd_regs), .rd_tag(opnd_tags)
  );

  tvs_cfg_regs #(.LEN_W(LEN_W)) u_cfg (
    .clk(clk), .rst(rst),
    .len_we(len_we), .len_val(len_val),
    .mode_we(mode_we), .mode_val(mode_val),
    .len_q(cfg_len), .mode_q(cfg_mode)
  );

  tvs_issue_loop #(.REG_W(REG_W), .LEN_W(LEN_W), .OP_W(OP_W), .NOPND(NOPND)) u_loop (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_op(in_op), .in_regs(opnd_regs), .in_tags(opnd_tags),
    .cfg_len(cfg_len), .cfg_mode(cfg_mode),
    .in_ready(in_ready), .uop_valid(uop_valid), .uop_op(uop_op),
    .uop_regs(out_regs), .uop_last(uop_last), .pc_hold(pc_hold), .trap(trap)
  );
endmodule

// File: rtl/tvs_checker.sv
module tvs_checker #(
  parameter int OP_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_ready,
  input logic            uop_valid,
  input logic [OP_W-1:0] uop_op,
  input logic            uop_last,
  input logic            pc_hold,
  input logic            trap
);
  // R5
  hold_needs_uop_chk: assert property (@(posedge clk) disable iff (rst)
    pc_hold |-> uop_valid);
  // R5
  hold_before_last_chk: assert property (@(posedge clk) disable iff (rst)
    (uop_valid && !uop_last) |-> pc_hold);
  // R6
  hold_blocks_ready_chk: assert property (@(posedge clk) disable iff (rst)
    pc_hold |-> !in_ready);
  // R6
  ready_at_last_chk: assert property (@(posedge clk) disable iff (rst)
    (uop_valid && uop_last) |-> in_ready);
  // R2
  loop_continues_chk: assert property (@(posedge clk) disable iff (rst)
    (uop_valid && !uop_last) |=> uop_valid);
  // R2
  op_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (uop_valid && !uop_last) |=> $stable(uop_op));
  // R7
  trap_alone_chk: assert property (@(posedge clk) disable iff (rst)
    trap |-> !uop_valid);
  // R7
  trap_cause_chk: assert property (@(posedge clk) disable iff (rst)
    trap |-> $past(in_valid && in_ready));
endmodule

bind tagvec_issue_seq tvs_checker #(.OP_W(OP_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .uop_valid(uop_valid), .uop_op(uop_op), .uop_last(uop_last),
  .pc_hold(pc_hold), .trap(trap)
);

// File: tb/test_tagvec_issue_seq.sv
`timescale 1ns/1ps
module test_tagvec_issue_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tag_we = 0, tag_val = 0, len_we = 0, mode_we = 0, mode_val = 0, in_valid = 0;
  logic [4:0] tag_idx = 0, in_rd = 0, in_rs1 = 0, in_rs2 = 0;
  logic [5:0] len_val = 0;
  logic [7:0] in_op = 0;
  logic in_ready, uop_valid, uop_last, pc_hold, trap;
  logic [7:0] uop_op;
  logic [4:0] uop_rd, uop_rs1, uop_rs2;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] tmod = '0;
  int len_m = 0;
  bit mode_m = 0;

  always #2.5 clk = ~clk;

  tagvec_issue_seq i_tagvec_issue_seq (
    .clk(clk), .rst(rst), .tag_we(tag_we), .tag_idx(tag_idx), .tag_val(tag_val),
    .len_we(len_we), .len_val(len_val), .mode_we(mode_we), .mode_val(mode_val),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2),
    .uop_valid(uop_valid), .uop_op(uop_op), .uop_rd(uop_rd), .uop_rs1(uop_rs1),
    .uop_rs2(uop_rs2), .uop_last(uop_last), .pc_hold(pc_hold), .trap(trap)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr_tag(input int r, input bit v);
    @(negedge clk);
    tag_we = 1; tag_idx = 5'(r); tag_val = v;
    @(negedge clk);
    tag_we = 0;
    tmod[r] = v;
  endtask

  task automatic wr_len(input int l);
    @(negedge clk);
    len_we = 1; len_val = 6'(l);
    @(negedge clk);
    len_we = 0;
    len_m = l;
  endtask

  task automatic wr_mode(input bit m);
    @(negedge clk);
    mode_we = 1; mode_val = m;
    @(negedge clk);
    mode_we = 0;
    mode_m = m;
  endtask

  function automatic int stepped(input int r, input bit t, input int i);
    return t ? ((r + i) % 32) : r;
  endfunction

  // poke_mid: rewrite length, mode and rs1 tag during the loop (R9)
  // poke_same: tag rs2 on the accept edge (R8)
  task automatic send(input int op, input int rd, input int rs1, input int rs2,
                      input bit poke_mid, input bit poke_same, input string req);
    bit t0, t1, t2, anyt, trp;
    int n;
    t0 = tmod[rd]; t1 = tmod[rs1]; t2 = tmod[rs2];
    anyt = t0 | t1 | t2;
    trp = anyt & mode_m;
    n = anyt ? ((len_m < 2) ? 1 : len_m) : 1;
    @(negedge clk);
    check(in_ready == 1, {req, " ready before accept"}, in_ready, 1);
    in_valid = 1; in_op = 8'(op); in_rd = 5'(rd); in_rs1 = 5'(rs1); in_rs2 = 5'(rs2);
    if (poke_same) begin tag_we = 1; tag_idx = 5'(rs2); tag_val = 1; end
    @(negedge clk);
    in_valid = 0; tag_we = 0;
    if (poke_same) tmod[rs2] = 1;
    if (trp) begin
      check(trap == 1, {req, " R7 trap strobe"}, trap, 1);
      check(uop_valid == 0, {req, " R7 no uop"}, uop_valid, 0);
      check(in_ready == 1, {req, " R7 ready"}, in_ready, 1);
      @(negedge clk);
      check(trap == 0, {req, " R7 trap one cycle"}, trap, 0);
      check(uop_valid == 0, {req, " R7 no uop later"}, uop_valid, 0);
    end else begin
      for (int i = 0; i < n; i++) begin
        check(trap == 0, {req, " no trap"}, trap, 0);
        check(uop_valid == 1, {req, " R2 uop valid"}, uop_valid, 1);
        check(uop_op == 8'(op), {req, " R2 op"}, uop_op, op);
        check(uop_rd == 5'(stepped(rd, t0, i)), {req, " R3 rd"}, uop_rd, stepped(rd, t0, i));
        check(uop_rs1 == 5'(stepped(rs1, t1, i)), {req, " R3 rs1"}, uop_rs1, stepped(rs1, t1, i));
        check(uop_rs2 == 5'(stepped(rs2, t2, i)), {req, " R3 rs2"}, uop_rs2, stepped(rs2, t2, i));
        check(uop_last == (i == n - 1), {req, " R2 last"}, uop_last, int'(i == n - 1));
        check(pc_hold == (i != n - 1), {req, " R5 pc_hold"}, pc_hold, int'(i != n - 1));
        check(in_ready == (i == n - 1), {req, " R6 in_ready"}, in_ready, int'(i == n - 1));
        if (poke_mid && i == 0) begin
          len_we = 1; len_val = 6'd2; mode_we = 1; mode_val = 1;
          tag_we = 1; tag_idx = 5'(rs1); tag_val = 0;
        end else begin
          len_we = 0; mode_we = 0; tag_we = 0;
        end
        @(negedge clk);
      end
      len_we = 0; mode_we = 0; tag_we = 0;
      if (poke_mid) begin len_m = 2; mode_m = 1; tmod[rs1] = 0; end
      check(uop_valid == 0, {req, " idle after last"}, uop_valid, 0);
      check(pc_hold == 0, {req, " R5 hold released"}, pc_hold, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R10 reset state
    check(uop_valid == 0, "R10 uop_valid", uop_valid, 0);
    check(trap == 0, "R10 trap", trap, 0);
    check(in_ready == 1, "R10 in_ready", in_ready, 1);
    check(pc_hold == 0, "R10 pc_hold", pc_hold, 0);
    // R10 tags clear and length 0: single issue
    send(8'h11, 5, 6, 7, 0, 0, "R10 R1");

    // R1 R2 R3 R4 sweep: lengths 0..6 against every tag pattern
    for (int l = 0; l <= 6; l++) begin
      wr_len(l);
      for (int p = 0; p < 8; p++) begin
        wr_tag(3, p[0]); wr_tag(10, p[1]); wr_tag(30, p[2]);
        send(16 * l + p, 3, 10, 30, 0, 0, (p == 0) ? "R1 sweep" : "R2 R4 sweep");
      end
    end

    // R3 wrap at 31 with length 32, shared register number
    wr_tag(3, 0); wr_tag(10, 0); wr_tag(30, 0);
    wr_tag(31, 1);
    wr_len(32);
    send(8'h5a, 31, 31, 4, 0, 0, "R3 wrap");

    // R7 trap mode over every tag pattern
    wr_tag(31, 0);
    wr_len(4);
    wr_mode(1);
    for (int p = 0; p < 8; p++) begin
      wr_tag(1, p[0]); wr_tag(2, p[1]); wr_tag(9, p[2]);
      send(8'h70 + p, 1, 2, 9, 0, 0, "R7 trap sweep");
    end
    // R7 back-to-back traps
    send(8'h7e, 1, 2, 9, 0, 0, "R7 second trap");
    wr_mode(0);

    // R9 writes during a loop do not disturb it
    wr_tag(1, 0); wr_tag(2, 1); wr_tag(9, 0);
    wr_len(5);
    send(8'h90, 1, 2, 9, 1, 0, "R9 mid-loop");
    // new settings now apply: trap mode, rs1 untagged -> untagged single
    send(8'h91, 1, 2, 9, 0, 0, "R9 after");
    wr_tag(2, 1);
    send(8'h92, 1, 2, 9, 0, 0, "R9 trap applies");
    wr_mode(0);

    // R8 same-edge tag write sees old tag, next instruction sees new
    wr_tag(2, 0);
    wr_len(3);
    send(8'hb0, 1, 2, 12, 0, 1, "R8 same edge");
    send(8'hb1, 1, 2, 12, 0, 0, "R8 next");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule